// File: doc/BRIEF.md
# Multicycle 16-bit Register Processor

This block is a compact processor core built around eight 16-bit general registers. The top register, R7, also holds the address of the next instruction word. It reaches memory and I/O only through a single synchronous memory bus. That bus consists of an address, a write-data word, a read-data word and a write strobe. The core runs each instruction as a short series of clocked steps.

One instruction word carries a 3-bit operation code and two 3-bit register indices. The low seven bits are zero. Seven operations are defined:

- a register copy
- a load of the following word (immediate)
- add and subtract, which also update an internal result register G
- a load from memory
- a store to memory
- a copy that happens only when G is nonzero

Because R7 is an ordinary register, a copy into R7 acts as a jump, and a conditional copy into R7 acts as a conditional branch.

The bus has a fixed latency. The memory returns the word at the address presented in one cycle during the next cycle. There is no back-pressure on the bus, so no handshake is needed. The `run` pin lets a new instruction begin. The `done` pin marks the end of each instruction with a one-cycle pulse.

Top module: `mc16_core`

## Requirements
- R1: While `rst_n` is low, all registers and G clear to zero, the sequencer returns to the fetch step, and `mem_addr`, `mem_we` and `done` are all zero.
- R2: An instruction word is decoded as follows: the operation is in bits 15:13, the destination index X is in bits 12:10, and the source index Y is in bits 9:7.
- R3: Operation 000 copies register Y into register X. Reading R7 this way yields the address of the word after the instruction.
- R4: Operation 001 loads register X with the whole word that follows the instruction. Execution resumes after that word.
- R5: Operation 010 computes X+Y and operation 011 computes X−Y, both modulo 2^16. The result goes to register X and to G.
- R6: Operation 100 loads register X from memory at the address held in register Y.
- R7: Operation 101 raises `mem_we` for exactly one cycle. In that cycle `mem_addr` holds register Y and `mem_wdata` holds register X.
- R8: Operation 110 copies register Y into register X only when G is nonzero. Otherwise X keeps its value.
- R9: Writing R7 with any operation redirects the next fetch to the written value.
- R10: A new instruction begins only when `run` is high at the fetch step. While it waits, `mem_we` stays low and `mem_addr` does not change.
- R11: `done` is high for exactly one cycle, in the cycle after the instruction's final write. With `run` held high, operations 000, 010, 011 and 110 take 4 cycles, a store takes 5 cycles, and operations 001 and 100 take 6 cycles.
- R12: Each read presents its address for a full cycle and captures `mem_rdata` in the following cycle. This matches a memory with one cycle of read latency.
- R13: Operation 111 changes no register and no memory word. It still completes with a `done` pulse after 4 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Permits the next instruction to start |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Store strobe |
| done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
Two events can land on the same clock edge: a register being read and rewritten (as in X−X, or R7 read while it is being incremented), and `done` rising while `run` falls. The bench covers the first case with a program that subtracts a register from itself, then issues a conditional copy that must be skipped, and stores the result. The program also reads R7, jumps and branches. Every store on the bus is compared in order against a queue of expected words, so skipped stores and wrong values are both caught. For the second case, `run` is dropped on the very cycle a `done` pulse is seen. The bench then confirms that the bus stays idle and unchanged until `run` returns, after which the remaining stores must still arrive.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_MV   = 3'b000,
    OP_MVI  = 3'b001,
    OP_ADD  = 3'b010,
    OP_SUB  = 3'b011,
    OP_LD   = 3'b100,
    OP_ST   = 3'b101,
    OP_MVNZ = 3'b110,
    OP_RSV  = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    S_FETCH,
    S_F1,
    S_F2,
    S_EXEC,
    S_D1,
    S_D2,
    S_ST
  } state_e;
endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          pc_inc,
  input  logic [AW-1:0] raddr_x,
  input  logic [AW-1:0] raddr_y,
  output logic [DW-1:0] rdata_x,
  output logic [DW-1:0] rdata_y,
  output logic [DW-1:0] pc
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == NREG - 1) begin : g_pc
      // a direct write outranks the increment
      always_ff @(posedge clk) begin
        if (!rst_n)                        regs[i] <= '0;
        else if (we && waddr == AW'(i))    regs[i] <= wdata;
        else if (pc_inc)                   regs[i] <= regs[i] + DW'(1);
      end
    end else begin : g_gp
      always_ff @(posedge clk) begin
        if (!rst_n)                        regs[i] <= '0;
        else if (we && waddr == AW'(i))    regs[i] <= wdata;
      end
    end
  end

  assign rdata_x = regs[raddr_x];
  assign rdata_y = regs[raddr_y];
  assign pc      = regs[NREG-1];

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !(we && waddr == AW'(NREG-1))) |=> regs[NREG-1] == $past(regs[NREG-1]) + DW'(1));
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y
);
  always_comb y = sub ? (a - b) : (a + b);
endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG),
  localparam int IRW = OPW + 2 * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] rx_val,
  input  logic [DW-1:0] ry_val,
  input  logic [DW-1:0] alu_y,
  input  logic [DW-1:0] pc,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          done,
  output logic          rf_we,
  output logic [AW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          pc_inc,
  output logic [AW-1:0] raddr_x,
  output logic [AW-1:0] raddr_y,
  output logic          alu_sub
);
  state_e        state;
  logic [IRW-1:0] ir_q;
  logic [DW-1:0] g_q, addr_q, wdat_q;
  logic          we_q, done_q;
  op_e           op;

  assign op       = op_e'(ir_q[IRW-1 -: OPW]);
  assign raddr_x  = ir_q[IRW-OPW-1 -: AW];
  assign raddr_y  = ir_q[IRW-OPW-AW-1 -: AW];
  assign rf_waddr = raddr_x;
  assign alu_sub  = (op == OP_SUB);

  always_comb begin
    rf_we    = 1'b0;
    rf_wdata = ry_val;
    pc_inc   = 1'b0;
    case (state)
      S_FETCH: pc_inc = run;
      S_EXEC: begin
        case (op)
          OP_MV:          rf_we = 1'b1;
          OP_ADD, OP_SUB: begin rf_we = 1'b1; rf_wdata = alu_y; end
          OP_MVNZ:        rf_we = (g_q != '0);
          OP_MVI:         pc_inc = 1'b1;
          default:        rf_we = 1'b0;
        endcase
      end
      S_D2: begin rf_we = 1'b1; rf_wdata = mem_rdata; end
      default: rf_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_FETCH;
      ir_q   <= '0;
      g_q    <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      we_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_FETCH: if (run) begin addr_q <= pc; state <= S_F1; end
        S_F1:    state <= S_F2;
        S_F2:    begin ir_q <= mem_rdata[DW-1 -: IRW]; state <= S_EXEC; end
        S_EXEC: begin
          case (op)
            OP_ADD, OP_SUB: begin g_q <= alu_y; done_q <= 1'b1; state <= S_FETCH; end
            OP_MVI: begin addr_q <= pc; state <= S_D1; end
            OP_LD:  begin addr_q <= ry_val; state <= S_D1; end
            OP_ST:  begin addr_q <= ry_val; wdat_q <= rx_val; we_q <= 1'b1; state <= S_ST; end
            default: begin done_q <= 1'b1; state <= S_FETCH; end
          endcase
        end
        S_D1:    state <= S_D2;
        S_D2:    begin done_q <= 1'b1; state <= S_FETCH; end
        S_ST:    begin we_q <= 1'b0; done_q <= 1'b1; state <= S_FETCH; end
        default: state <= S_FETCH;
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;
  assign mem_we    = we_q;
  assign done      = done_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  store_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!mem_we && done));
  // R10
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && !run) |=> (state == S_FETCH && $stable(mem_addr)));
  // R5
  g_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == S_EXEC && (op == OP_ADD || op == OP_SUB)) |=> $stable(g_q));
endmodule

// File: rtl/mc16_core.sv
module mc16_core #(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          done
);
  localparam int AW = $clog2(NREG);

  logic          rf_we, pc_inc, alu_sub;
  logic [AW-1:0] rf_waddr, raddr_x, raddr_y;
  logic [DW-1:0] rf_wdata, rx_val, ry_val, pc, alu_y;

  mc16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .pc_inc(pc_inc), .raddr_x(raddr_x), .raddr_y(raddr_y),
    .rdata_x(rx_val), .rdata_y(ry_val), .pc(pc)
  );

  mc16_alu #(.DW(DW)) u_alu (
    .a(rx_val), .b(ry_val), .sub(alu_sub), .y(alu_y)
  );

  mc16_ctrl #(.DW(DW), .NREG(NREG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .mem_rdata(mem_rdata),
    .rx_val(rx_val), .ry_val(ry_val), .alu_y(alu_y), .pc(pc),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .done(done),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .pc_inc(pc_inc),
    .raddr_x(raddr_x), .raddr_y(raddr_y), .alu_sub(alu_sub)
  );
endmodule

// File: tb/tb_mc16_core.sv
module tb_mc16_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [15:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_we, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc16_core dut (
    .clk(clk), .rst_n(rst_n), .run(run), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .done(done)
  );

  function automatic logic [15:0] prog(int a);
    case (a)
      0: return 16'h2400;  1: return 16'h0001;   // R1 <- 1
      2: return 16'h2800;  3: return 16'h0040;   // R2 <- 0x40
      4: return 16'h2C00;  5: return 16'h7FFF;   // R3 <- 0x7FFF
      6: return 16'h4C80;                        // R3 += R1
      7: return 16'hAD00;                        // [R2] <- R3
      8: return 16'h4880;                        // R2 += R1
      9: return 16'h3000; 10: return 16'h0001;   // R4 <- 1
      11: return 16'h7180;                       // R4 -= R3
      12: return 16'hB100;                       // [R2] <- R4
      13: return 16'h4880;
      14: return 16'h1780;                       // R5 <- R7
      15: return 16'hB500;
      16: return 16'h4880;
      17: return 16'h9800;                       // R6 <- [R0]
      18: return 16'hB900;
      19: return 16'h4880;
      20: return 16'h7B00;                       // R6 -= R6, G=0
      21: return 16'hD880;                       // mvnz skipped
      22: return 16'hB900;
      23: return 16'h4880;
      24: return 16'hD880;                       // mvnz taken
      25: return 16'hB900;
      26: return 16'h3C00; 27: return 16'd30;    // jump
      28: return 16'hA500; 29: return 16'hA500;  // must be skipped
      30: return 16'h4880;
      31: return 16'hE480;                       // reserved code
      32: return 16'hA500;
      33: return 16'h3400; 34: return 16'd37;
      35: return 16'hDE80;                       // branch taken
      36: return 16'hA500;                       // must be skipped
      37: return 16'h4880;
      38: return 16'hA900;
      39: return 16'h2000; 40: return 16'd39;
      41: return 16'h1C00;                       // loop
      default: return 16'h0000;
    endcase
  endfunction

  logic [15:0] mem [128];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= prog(i);
    end else if (mem_we) begin
      mem[mem_addr[6:0]] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr[6:0]];
  end

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  typedef struct {
    logic [15:0] a;
    logic [15:0] d;
    string       tag;
  } exp_t;
  exp_t q[$];
  int nwrites = 0;

  task automatic push_exp(logic [15:0] a, logic [15:0] d, string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  // store monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8/R9 unexpected store", {mem_addr, mem_wdata}, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(mem_addr == e.a && mem_wdata == e.d, e.tag, {mem_addr, mem_wdata}, {e.a, e.d});
      end
      nwrites++;
    end
  end

  // done timing monitor
  int cyc = 0;
  always @(posedge clk) cyc++;
  int pulses = 0, last_cyc = 0, wide = 0;
  bit prev_done = 1'b0;
  function automatic int exp_gap(int p);
    case (p)
      2: return 6; 3: return 6; 4: return 4; default: return 5;
    endcase
  endfunction
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (prev_done) wide++;
      pulses++;
      if (pulses >= 2 && pulses <= 5)
        chk(cyc - last_cyc == exp_gap(pulses), "R11/R12 instruction length",
            32'(cyc - last_cyc), 32'(exp_gap(pulses)));
      last_cyc = cyc;
    end
    prev_done = rst_n && done;
  end

  initial begin
    bit ok;
    logic [15:0] hold_addr;
    push_exp(16'h0040, 16'h8000, "R2/R4/R5/R7 add wraps to sign bit");
    push_exp(16'h0041, 16'h8001, "R5 sub modulo");
    push_exp(16'h0042, 16'h000F, "R3 copy of program counter");
    push_exp(16'h0043, 16'h2400, "R6/R12 load from memory");
    push_exp(16'h0044, 16'h0000, "R8 conditional copy skipped when G zero");
    push_exp(16'h0045, 16'h0001, "R8 conditional copy taken");
    push_exp(16'h0046, 16'h0001, "R9/R13 jump and reserved code");
    push_exp(16'h0047, 16'h0047, "R9 conditional branch");

    repeat (3) @(negedge clk);
    chk(mem_addr == 16'h0, "R1 reset address", 32'(mem_addr), 32'h0);
    chk(mem_we == 1'b0, "R1 reset strobe", 32'(mem_we), 32'h0);
    chk(done == 1'b0, "R1 reset done", 32'(done), 32'h0);
    rst_n = 1'b1;
    ok = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (mem_we || done || mem_addr != 16'h0) ok = 1'b0;
    end
    chk(ok, "R10 idle while run low after reset", 32'(mem_addr), 32'h0);
    run = 1'b1;

    // drop run on the same cycle as the eighth done pulse
    repeat (8) begin
      do @(negedge clk); while (!done);
    end
    run = 1'b0;
    ok = 1'b1;
    @(negedge clk);
    hold_addr = mem_addr;
    repeat (20) begin
      if (mem_we || done || mem_addr != hold_addr) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R10 paused with run low", 32'(mem_addr), 32'(hold_addr));
    run = 1'b1;

    while (nwrites < 8) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(q.size() == 0 && nwrites == 8, "R7/R9 store count", 32'(nwrites), 32'd8);
    chk(wide == 0, "R11 done width", 32'(wide), 32'd0);
    chk(pulses > 20, "R11 done pulses seen", 32'(pulses), 32'd21);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 run did not complete actual=hung expected=finish");
      summary();
      $finish;
    end
  end
endmodule